// File: doc/BRIEF.md
# Indirect Scratchpad Register Unit

This unit holds a 64-entry by 8-bit scratchpad register file together with a 6-bit index pointer that is treated as two 3-bit halves. Each cycle one operation is presented on the command inputs. The operation can load one half of the pointer from a 3-bit immediate, copy the whole pointer to or from the data path, or read, write or decrement a scratchpad register chosen by a 4-bit selector.

Selector values 0 to 11 name registers 0 to 11 directly. Values 12 to 14 reach any of the 64 registers through the pointer. Value 13 steps the low half of the pointer up by one after the access, and value 14 steps it down by one. The step wraps inside the low three bits and never touches the high half. This lets a program walk a block of eight registers in a loop. The unit also drives a loop-test flag that is high while the low half is not 7.

A few registers have fixed roles elsewhere in the processor. Register 9 holds the saved status byte, registers 10 and 11 form the H pair, and registers 14 and 15 form the Q pair. These are exported continuously.

Top module: `sp_unit`

## Requirements
- R1: After reset the pointer is 0, every scratchpad register is 0, and the loop-test flag is 1.
- R2: Command code 1 (load high) writes `imm_i` into pointer bits 5:3 and keeps bits 2:0. Command code 2 (load low) writes `imm_i` into bits 2:0 and keeps bits 5:3. Both take effect at the next rising edge.
- R3: Command code 3 loads the pointer from `wdata_i[5:0]`. During command code 4, `rdata_o` shows `{2'b00, pointer}`.
- R4: Command codes 5 (read), 6 (write) and 7 (decrement) are register commands. With selector values 0 to 11 they address that register number. A read shows the register on `rdata_o` in the same cycle, and a write stores `wdata_i` at the next edge.
- R5: Selector 12 addresses the register whose number is the pointer value and leaves the pointer unchanged.
- R6: Selector 13 addresses through the pointer and then adds 1 to bits 2:0 only. The step from 7 wraps to 0, and bits 5:3 keep their value.
- R7: Selector 14 addresses through the pointer and then subtracts 1 from bits 2:0 only. The step from 0 wraps to 7, and bits 5:3 keep their value.
- R8: Command code 7 replaces the addressed register with its value minus 1, modulo 256. During that cycle `rdata_o` shows the value before the decrement.
- R9: A register command with selector 15 raises `err_o` in that cycle, writes nothing, leaves the pointer unchanged and drives `rdata_o` to 0. At all other times `err_o` is 0.
- R10: `lo_not7_o` is 1 exactly when pointer bits 2:0 differ from 3'b111.
- R11: `status_o` always shows register 9, `hpair_o` shows {register 10, register 11}, and `qpair_o` shows {register 14, register 15}.
- R12: Command code 0 changes nothing, and `rdata_o` is 0 for command codes 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Command code |
| field_i | input | 4 | Register selector for register commands |
| imm_i | input | 3 | Immediate for loading one half of the pointer |
| wdata_i | input | 8 | Write data, and the pointer load value |
| rdata_o | output | 8 | Read data of the current command |
| ptr_o | output | 6 | Current pointer value |
| lo_not7_o | output | 1 | Loop test: the low half of the pointer is not 7 |
| err_o | output | 1 | Illegal selector on a register command |
| status_o | output | 8 | Register 9 |
| hpair_o | output | 16 | Registers 10 and 11 |
| qpair_o | output | 16 | Registers 14 and 15 |

## Verification
The register commands are tried with direct selectors and with all three indirect selectors. Comparing the two kinds of access tells a selector that decoded to the wrong address apart from a correct one. The bench walks the pointer up across 7 and down across 0 with a nonzero high half. Those two walks expose any carry into the high half or borrow from it, and they move the loop-test flag through both of its values. Decrements of 0x5A and of 0x00 separate plain subtraction from the wrap to 0xFF. Selector 15 is applied with read, write and decrement. The bench then watches the data, the pointer and the exported register pairs, so a command that should be ignored but leaks into state is caught.

// File: rtl/sp_pkg.sv
package sp_pkg;

    localparam int SP_DATA_W = 8;
    localparam int SP_HALF_W = 3;
    localparam int SP_ADDR_W = 2 * SP_HALF_W;
    localparam int SP_SEL_W  = 4;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_LD_HI  = 3'd1,
        OP_LD_LO  = 3'd2,
        OP_PTR_WR = 3'd3,
        OP_PTR_RD = 3'd4,
        OP_REG_RD = 3'd5,
        OP_REG_WR = 3'd6,
        OP_REG_DEC = 3'd7
    } sp_op_e;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } sp_step_e;

    typedef struct packed {
        logic [SP_HALF_W-1:0] hi;
        logic [SP_HALF_W-1:0] lo;
    } sp_ptr_t;

endpackage

// File: rtl/sp_sel_decode.sv
module sp_sel_decode
    import sp_pkg::*;
#(
    parameter int ADDR_W     = SP_ADDR_W,
    parameter int SEL_W      = SP_SEL_W,
    parameter int DIRECT_CNT = 12
) (
    input  sp_op_e             op_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [ADDR_W-1:0]  ptr_i,
    output logic [ADDR_W-1:0]  addr_o,
    output sp_step_e           step_o,
    output logic               reg_cmd_o,
    output logic               illegal_o,
    output logic               we_o,
    output logic               dec_o
);

    localparam logic [SEL_W-1:0] SEL_IND     = SEL_W'(DIRECT_CNT);
    localparam logic [SEL_W-1:0] SEL_IND_INC = SEL_W'(DIRECT_CNT + 1);
    localparam logic [SEL_W-1:0] SEL_IND_DEC = SEL_W'(DIRECT_CNT + 2);

    logic direct;

    always_comb begin
        reg_cmd_o = (op_i == OP_REG_RD) || (op_i == OP_REG_WR) || (op_i == OP_REG_DEC);
        direct    = (sel_i < SEL_IND);
        illegal_o = reg_cmd_o && (sel_i > SEL_IND_DEC);
        addr_o    = direct ? ADDR_W'(sel_i) : ptr_i;
        we_o      = ((op_i == OP_REG_WR) || (op_i == OP_REG_DEC)) && !illegal_o;
        dec_o     = (op_i == OP_REG_DEC);
        step_o    = STEP_NONE;
        if (reg_cmd_o && !illegal_o) begin
            if (sel_i == SEL_IND_INC) begin
                step_o = STEP_INC;
            end else if (sel_i == SEL_IND_DEC) begin
                step_o = STEP_DEC;
            end
        end
    end

endmodule

// File: rtl/sp_ptr_reg.sv
module sp_ptr_reg
    import sp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  sp_op_e               op_i,
    input  logic [SP_HALF_W-1:0] imm_i,
    input  logic [SP_ADDR_W-1:0] load_i,
    input  sp_step_e             step_i,
    output logic [SP_ADDR_W-1:0] ptr_o,
    output logic                 lo_not7_o
);

    sp_ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        unique case (op_i)
            OP_LD_HI:  ptr_d.hi = imm_i;
            OP_LD_LO:  ptr_d.lo = imm_i;
            OP_PTR_WR: ptr_d    = sp_ptr_t'(load_i);
            default:   ptr_d    = ptr_q;
        endcase
        if (step_i == STEP_INC) begin
            ptr_d.lo = ptr_q.lo + SP_HALF_W'(1);
        end else if (step_i == STEP_DEC) begin
            ptr_d.lo = ptr_q.lo - SP_HALF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr_o     = ptr_q;
    assign lo_not7_o = ~&ptr_q.lo;

    a_r2_load_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LD_HI) |=> (ptr_q.hi == $past(imm_i)) && (ptr_q.lo == $past(ptr_q.lo)));

    a_r2_load_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LD_LO) |=> (ptr_q.lo == $past(imm_i)) && (ptr_q.hi == $past(ptr_q.hi)));

    a_r6_inc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == STEP_INC) |=>
            (ptr_q.lo == $past(ptr_q.lo) + SP_HALF_W'(1)) && (ptr_q.hi == $past(ptr_q.hi)));

    a_r7_dec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == STEP_DEC) |=>
            (ptr_q.lo == $past(ptr_q.lo) - SP_HALF_W'(1)) && (ptr_q.hi == $past(ptr_q.hi)));

endmodule

// File: rtl/sp_regfile.sv
module sp_regfile
    import sp_pkg::*;
#(
    parameter int DATA_W = SP_DATA_W,
    parameter int ADDR_W = SP_ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                we_i,
    input  logic                dec_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [DATA_W-1:0]   status_o,
    output logic [2*DATA_W-1:0] hpair_o,
    output logic [2*DATA_W-1:0] qpair_o
);

    localparam int DEPTH   = 1 << ADDR_W;
    localparam int IDX_ST  = 9;
    localparam int IDX_H   = 10;
    localparam int IDX_Q   = 14;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] new_val;

    always_comb begin
        new_val = dec_i ? (mem_q[addr_i] - DATA_W'(1)) : wdata_i;
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we_i) begin
            mem_d[addr_i] = new_val;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cell
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem_q[g] <= '0;
                end else begin
                    mem_q[g] <= mem_d[g];
                end
            end
        end
    endgenerate

    assign rdata_o  = mem_q[addr_i];
    assign status_o = mem_q[IDX_ST];
    assign hpair_o  = {mem_q[IDX_H], mem_q[IDX_H+1]};
    assign qpair_o  = {mem_q[IDX_Q], mem_q[IDX_Q+1]};

    a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !dec_i) |=> (mem_q[$past(addr_i)] == $past(wdata_i)));

    a_r8_dec_one: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && dec_i) |=> (mem_q[$past(addr_i)] == $past(rdata_o) - DATA_W'(1)));

endmodule

// File: rtl/sp_unit.sv
module sp_unit
    import sp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             op_i,
    input  logic [SP_SEL_W-1:0]    field_i,
    input  logic [SP_HALF_W-1:0]   imm_i,
    input  logic [SP_DATA_W-1:0]   wdata_i,
    output logic [SP_DATA_W-1:0]   rdata_o,
    output logic [SP_ADDR_W-1:0]   ptr_o,
    output logic                   lo_not7_o,
    output logic                   err_o,
    output logic [SP_DATA_W-1:0]   status_o,
    output logic [2*SP_DATA_W-1:0] hpair_o,
    output logic [2*SP_DATA_W-1:0] qpair_o
);

    sp_op_e                op;
    sp_step_e              step;
    logic [SP_ADDR_W-1:0]  addr;
    logic [SP_ADDR_W-1:0]  ptr;
    logic [SP_DATA_W-1:0]  rf_rdata;
    logic                  reg_cmd, illegal, we, dec;

    assign op = sp_op_e'(op_i);

    sp_sel_decode u_dec (
        .op_i      (op),
        .sel_i     (field_i),
        .ptr_i     (ptr),
        .addr_o    (addr),
        .step_o    (step),
        .reg_cmd_o (reg_cmd),
        .illegal_o (illegal),
        .we_o      (we),
        .dec_o     (dec)
    );

    sp_ptr_reg u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .imm_i     (imm_i),
        .load_i    (wdata_i[SP_ADDR_W-1:0]),
        .step_i    (step),
        .ptr_o     (ptr),
        .lo_not7_o (lo_not7_o)
    );

    sp_regfile u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (addr),
        .we_i     (we),
        .dec_i    (dec),
        .wdata_i  (wdata_i),
        .rdata_o  (rf_rdata),
        .status_o (status_o),
        .hpair_o  (hpair_o),
        .qpair_o  (qpair_o)
    );

    always_comb begin
        rdata_o = '0;
        if (op == OP_PTR_RD) begin
            rdata_o = SP_DATA_W'(ptr);
        end else if (reg_cmd && !illegal) begin
            rdata_o = rf_rdata;
        end
    end

    assign err_o = illegal;
    assign ptr_o = ptr;

    a_r9_ptr_held: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (ptr_o == $past(ptr_o)));

    a_r9_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (rdata_o == '0));

    a_r9_pairs_held: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> $stable(hpair_o) && $stable(qpair_o) && $stable(status_o));

    a_r12_nop_held: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd0) |=> (ptr_o == $past(ptr_o)) && $stable(hpair_o) && $stable(qpair_o));

endmodule

// File: tb/sp_unit_tb.sv
`timescale 1ns/1ps
module sp_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  op;
    logic [3:0]  field;
    logic [2:0]  imm;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic [5:0]  ptr;
    logic        lo_not7;
    logic        err;
    logic [7:0]  status;
    logic [15:0] hpair, qpair;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [7:0] m_reg [64];
    logic [5:0] m_ptr;

    always #2.5 clk = ~clk;

    sp_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .field_i(field), .imm_i(imm),
        .wdata_i(wdata), .rdata_o(rdata), .ptr_o(ptr), .lo_not7_o(lo_not7),
        .err_o(err), .status_o(status), .hpair_o(hpair), .qpair_o(qpair)
    );

    task automatic check(input string req, input string what, input logic [15:0] act,
                         input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 64; i++) m_reg[i] = 8'h00;
        m_ptr = 6'd0;
    endtask

    task automatic check_state(input string req);
        check(req, "ptr", {10'd0, ptr}, {10'd0, m_ptr});
        check("R10", "loop flag", {15'd0, lo_not7}, {15'd0, (m_ptr[2:0] != 3'b111)});
        check("R11", "status", {8'd0, status}, {8'd0, m_reg[9]});
        check("R11", "hpair", hpair, {m_reg[10], m_reg[11]});
        check("R11", "qpair", qpair, {m_reg[14], m_reg[15]});
    endtask

    task automatic step(input logic [2:0] o, input logic [3:0] f, input logic [2:0] im,
                        input logic [7:0] wd, input string req);
        logic       is_reg, ill;
        logic [5:0] a;
        logic [7:0] exp_rd;
        op = o; field = f; imm = im; wdata = wd;
        is_reg = (o >= 3'd5);
        ill    = is_reg && (f == 4'd15);
        a      = (f < 4'd12) ? {2'b00, f} : m_ptr;
        exp_rd = 8'h00;
        if (o == 3'd4) exp_rd = {2'b00, m_ptr};
        else if (is_reg && !ill) exp_rd = m_reg[a];
        #1;
        check(req, "rdata", {8'd0, rdata}, {8'd0, exp_rd});
        check("R9", "err", {15'd0, err}, {15'd0, ill});
        @(posedge clk);
        case (o)
            3'd1: m_ptr[5:3] = im;
            3'd2: m_ptr[2:0] = im;
            3'd3: m_ptr = wd[5:0];
            3'd6: if (!ill) m_reg[a] = wd;
            3'd7: if (!ill) m_reg[a] = m_reg[a] - 8'd1;
            default: ;
        endcase
        if (is_reg && !ill && f == 4'd13) m_ptr[2:0] = m_ptr[2:0] + 3'd1;
        if (is_reg && !ill && f == 4'd14) m_ptr[2:0] = m_ptr[2:0] - 3'd1;
        #1;
        check_state(req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        op = 3'd0; field = 4'd0; imm = 3'd0; wdata = 8'd0;
        repeat (3) @(posedge clk);
        #1;
        model_reset();
        rst_n = 1'b1;
        #1;
    endtask

    // {op, field, imm, wdata}
    localparam int NV = 26;
    localparam logic [17:0] VEC [NV] = '{
        {3'd6, 4'd0,  3'd0, 8'h11},   // R4 direct write
        {3'd6, 4'd5,  3'd0, 8'h5A},
        {3'd6, 4'd9,  3'd0, 8'hC3},   // R11 status
        {3'd6, 4'd10, 3'd0, 8'h12},
        {3'd6, 4'd11, 3'd0, 8'h34},
        {3'd5, 4'd5,  3'd0, 8'h00},   // R4 direct read
        {3'd1, 4'd0,  3'd1, 8'h00},   // R2 hi=1
        {3'd2, 4'd0,  3'd6, 8'h00},   // R2 lo=6 -> 14
        {3'd6, 4'd13, 3'd0, 8'h77},   // R6 r14, ptr 15
        {3'd6, 4'd13, 3'd0, 8'h88},   // R6 r15, lo wraps 7->0, ptr 8
        {3'd5, 4'd12, 3'd0, 8'h00},   // R5 read r8
        {3'd6, 4'd14, 3'd0, 8'h99},   // R7 write r8, lo wraps 0->7
        {3'd5, 4'd12, 3'd0, 8'h00},   // R5 read r15
        {3'd4, 4'd0,  3'd0, 8'h00},   // R3 ptr read
        {3'd3, 4'd0,  3'd0, 8'hFF},   // R3 ptr write 63
        {3'd5, 4'd3,  3'd0, 8'h00},
        {3'd7, 4'd5,  3'd0, 8'h00},   // R8 5A->59
        {3'd5, 4'd5,  3'd0, 8'h00},
        {3'd7, 4'd12, 3'd0, 8'h00},   // R8 r63 00->FF
        {3'd5, 4'd12, 3'd0, 8'h00},
        {3'd6, 4'd15, 3'd0, 8'hEE},   // R9 illegal write
        {3'd5, 4'd15, 3'd0, 8'h00},   // R9 illegal read
        {3'd7, 4'd15, 3'd0, 8'h00},   // R9 illegal decrement
        {3'd0, 4'd9,  3'd5, 8'h42},   // R12 nop
        {3'd2, 4'd0,  3'd3, 8'h00},   // R2 lo=3
        {3'd7, 4'd13, 3'd0, 8'h00}    // R6 R8 dec through pointer
    };

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check_state("R1");
        for (int f = 0; f < 12; f++) step(3'd5, 4'(f), 3'd0, 8'h00, "R1");
        step(3'd5, 4'd12, 3'd0, 8'h00, "R1");

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][17:15], VEC[i][14:11], VEC[i][10:8], VEC[i][7:0], "R4");
        end

        // full low-half walk up and down with hi = 5
        step(3'd3, 4'd0, 3'd0, 8'h28, "R3");
        for (int k = 0; k < 9; k++) step(3'd6, 4'd13, 3'd0, 8'(k + 1), "R6");
        for (int k = 0; k < 9; k++) step(3'd5, 4'd14, 3'd0, 8'h00, "R7");

        // R12 rdata stays 0 for pointer-only commands
        step(3'd1, 4'd0, 3'd7, 8'hAA, "R12");
        step(3'd3, 4'd0, 3'd0, 8'h0F, "R12");

        // R1 reset mid-run
        do_reset();
        check_state("R1");
        step(3'd5, 4'd5, 3'd0, 8'h00, "R1");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule